// File: doc/BRIEF.md
# DRAM Burst Column Order Generator

This block turns one accepted read or write command into the sequence of column offsets that a DRAM data path uses for each beat of the burst. The start column, the ordering style (sequential or interleaved), the read/write direction and the burst length are captured when the command strobe is seen. From the next clock on, the block emits one column index per beat, a valid flag, a flag for beat slots that carry no data, and a pulse on the final slot.

The burst length comes from a 2-bit mode field. It can fix the burst at eight beats, fix it at a chop of four, or let each command choose through a per-command chop input. A chopped burst still takes all eight beat slots, and the second four are flagged as idle. Writes override part of the start column: a full write always runs in plain ascending order, and a chopped write keeps only the group-select bit. A command that arrives while a burst is running waits in a single holding slot and starts on the cycle right after the running burst's eighth slot.

Top module: `burst_order_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, beat_valid, beat_idle, burst_done, len_err and beat_idx are all zero.
- R2: A command accepted with the block idle gives its first beat in the cycle after the strobe. beat_valid stays high for exactly eight consecutive slots, and burst_done is high only in the eighth slot.
- R3: A full-length read with mode_ilv=0 (sequential) counts upward inside the aligned group of four that holds the start, wrapping within that group. It then covers the other group with the same rotation: start 5 gives 5,6,7,4,1,2,3,0.
- R4: A full-length read with mode_ilv=1 (interleaved) gives slot k the index start XOR k: start 3 gives 3,2,1,0,7,6,5,4.
- R5: A full-length write ignores cmd_start and mode_ilv and always gives 0,1,2,3,4,5,6,7.
- R6: A chopped write uses only cmd_start[2]. It gives 0,1,2,3 when that bit is 0 and 4,5,6,7 when it is 1, followed by four slots with beat_idle=1 and beat_idx=0.
- R7: A chopped read keeps the group picked by cmd_start[2] and orders the four beats by mode_ilv as in R3/R4, restricted to that group: start 6 sequential gives 6,7,4,5, and start 5 interleaved gives 5,4,7,6. Its slots 5 to 8 have beat_idle=1 and beat_idx=0.
- R8: mode_len 2'b00 gives eight beats and mode_len 2'b10 gives a chop of four, in both cases whatever cmd_chop is. With mode_len 2'b01, cmd_chop=1 chops and cmd_chop=0 gives eight beats.
- R9: mode_len 2'b11 gives an eight-beat burst with len_err high in all eight of its slots. len_err is low for every other code.
- R10: A command strobed while a burst is running is held. Its first beat appears in the cycle right after the running burst's eighth slot.
- R11: While one command is already held, further strobes are dropped and produce no beats. A strobe in the same cycle that the held command launches is kept as the next held command.
- R12: All command and mode inputs are sampled only at the accepted strobe. Changing them during a burst does not alter that burst's beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_chop | input | 1 | Per-command chop choice, used when mode_len = 2'b01 (1 = four beats) |
| cmd_start | input | 3 | Starting column bits [2:0] |
| mode_len | input | 2 | Burst-length code: 00 eight, 01 per command, 10 four, 11 reserved |
| mode_ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| beat_valid | output | 1 | High in each of the eight beat slots of a burst |
| beat_idx | output | 3 | Column index of the current beat (0 on idle slots) |
| beat_idle | output | 1 | Slot carries no data (last four slots of a chop) |
| burst_done | output | 1 | High in the eighth slot |
| len_err | output | 1 | Burst was started with the reserved length code |

## Verification
A wrong slot counter shows up at once as a burst longer or shorter than eight slots: burst_done lands off the eighth valid cycle, or beat_valid drops early. A wrong captured start or ordering select changes beat_idx from the first beat, so the scoreboard catches it in the cycle after the strobe. A faulty holding slot shows up one burst later, as a gap, an overlap, or a stray burst where a dropped command should have left the outputs quiet.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;

   typedef enum logic [1:0] {
      LEN_FIXED8   = 2'b00,
      LEN_PERCMD   = 2'b01,
      LEN_FIXED4   = 2'b10,
      LEN_RESERVED = 2'b11
   } len_code_e;

   typedef struct packed {
      logic write;
      logic chop;
      logic ilv;
      logic err;
   } burst_mode_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_order_pkg::*;
(
   input  logic [1:0] len_code,
   input  logic       cmd_chop,
   output logic       chop,
   output logic       err
);

   len_code_e code;

   always_comb begin
      code = len_code_e'(len_code);
      chop = 1'b0;
      err  = 1'b0;
      unique case (code)
         LEN_FIXED8:   chop = 1'b0;
         LEN_PERCMD:   chop = cmd_chop;
         LEN_FIXED4:   chop = 1'b1;
         LEN_RESERVED: err  = 1'b1;
         default:      chop = 1'b0;
      endcase
   end

   always_comb begin
      assert_rsvd_full_R9: assert (!(err && chop))
         else $error("reserved length code produced a chop");
   end

endmodule

// File: rtl/burst_cmd_slot.sv
module burst_cmd_slot
   import burst_order_pkg::*;
#(
   parameter int IDX_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  burst_mode_t      cmd_mode,
   input  logic [IDX_W-1:0] cmd_start,
   input  logic             seq_free,
   output logic             launch_valid,
   output burst_mode_t      launch_mode,
   output logic [IDX_W-1:0] launch_start
);

   logic             held_q;
   burst_mode_t      held_mode_q;
   logic [IDX_W-1:0] held_start_q;
   logic             take_new;

   always_comb begin
      launch_valid = held_q ? seq_free : (cmd_valid && seq_free);
      launch_mode  = held_q ? held_mode_q  : cmd_mode;
      launch_start = held_q ? held_start_q : cmd_start;
      take_new     = cmd_valid && (held_q ? seq_free : !seq_free);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q       <= 1'b0;
         held_mode_q  <= '0;
         held_start_q <= '0;
      end else begin
         if (held_q && seq_free)
            held_q <= cmd_valid;
         else if (!held_q && cmd_valid && !seq_free)
            held_q <= 1'b1;
         if (take_new) begin
            held_mode_q  <= cmd_mode;
            held_start_q <= cmd_start;
         end
      end
   end

   property p_held_waits;
      @(posedge clk) disable iff (!rst_n)
         (held_q && !seq_free) |=> (held_q && $stable(held_start_q) && $stable(held_mode_q));
   endproperty
   assert_held_waits_R11: assert property (p_held_waits)
      else $error("held command changed before launch");

   property p_launch_only_free;
      @(posedge clk) disable iff (!rst_n)
         launch_valid |-> seq_free;
   endproperty
   assert_launch_free_R10: assert property (p_launch_only_free)
      else $error("launch while sequencer busy");

endmodule

// File: rtl/beat_order_table.sv
module beat_order_table
   import burst_order_pkg::*;
#(
   parameter int BEATS = 8
)(
   input  burst_mode_t                          mode,
   input  logic [$clog2(BEATS)-1:0]             start,
   output logic [BEATS-1:0][$clog2(BEATS)-1:0]  idx_tab,
   output logic [BEATS-1:0]                     idle_tab
);

   localparam int IDX_W = $clog2(BEATS);
   localparam int GRP_W = IDX_W - 1;

   logic [IDX_W-1:0] eff_start;

   always_comb begin
      if (!mode.write)
         eff_start = start;
      else if (mode.chop)
         eff_start = {start[IDX_W-1], {GRP_W{1'b0}}};
      else
         eff_start = '0;
   end

   for (genvar k = 0; k < BEATS; k++) begin : g_slot
      localparam logic [IDX_W-1:0] K = IDX_W'(k);
      logic [IDX_W-1:0] seq_idx;
      logic [IDX_W-1:0] ilv_idx;
      logic             idle;

      always_comb begin
         seq_idx[IDX_W-1]   = eff_start[IDX_W-1] ^ K[IDX_W-1];
         seq_idx[GRP_W-1:0] = eff_start[GRP_W-1:0] + K[GRP_W-1:0];
         ilv_idx            = eff_start ^ K;
         idle               = mode.chop && K[IDX_W-1];
         idle_tab[k]        = idle;
         if (idle)
            idx_tab[k] = '0;
         else if (mode.ilv)
            idx_tab[k] = ilv_idx;
         else
            idx_tab[k] = seq_idx;
      end
   end

endmodule

// File: rtl/beat_sequencer.sv
module beat_sequencer
   import burst_order_pkg::*;
#(
   parameter int BEATS = 8
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     launch_valid,
   input  burst_mode_t              launch_mode,
   input  logic [$clog2(BEATS)-1:0] launch_start,
   output logic                     seq_free,
   output logic                     beat_valid,
   output logic [$clog2(BEATS)-1:0] beat_idx,
   output logic                     beat_idle,
   output logic                     burst_done,
   output logic                     len_err
);

   localparam int               IDX_W = $clog2(BEATS);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(BEATS - 1);

   logic             active_q;
   logic [IDX_W-1:0] cnt_q;
   burst_mode_t      cur_mode_q;
   logic [IDX_W-1:0] cur_start_q;

   logic             nxt_active;
   logic [IDX_W-1:0] nxt_cnt;
   burst_mode_t      nxt_mode;
   logic [IDX_W-1:0] nxt_start;

   logic [BEATS-1:0][IDX_W-1:0] idx_tab;
   logic [BEATS-1:0]            idle_tab;

   assign seq_free = !active_q || (cnt_q == LAST);

   always_comb begin
      nxt_active = active_q;
      nxt_cnt    = cnt_q;
      nxt_mode   = cur_mode_q;
      nxt_start  = cur_start_q;
      if (launch_valid) begin
         nxt_active = 1'b1;
         nxt_cnt    = '0;
         nxt_mode   = launch_mode;
         nxt_start  = launch_start;
      end else if (active_q && cnt_q == LAST) begin
         nxt_active = 1'b0;
         nxt_cnt    = '0;
      end else if (active_q) begin
         nxt_cnt = cnt_q + 1'b1;
      end
   end

   beat_order_table #(.BEATS(BEATS)) i_table (
      .mode     (nxt_mode),
      .start    (nxt_start),
      .idx_tab  (idx_tab),
      .idle_tab (idle_tab)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         cnt_q       <= '0;
         cur_mode_q  <= '0;
         cur_start_q <= '0;
         beat_valid  <= 1'b0;
         beat_idx    <= '0;
         beat_idle   <= 1'b0;
         burst_done  <= 1'b0;
         len_err     <= 1'b0;
      end else begin
         active_q    <= nxt_active;
         cnt_q       <= nxt_cnt;
         cur_mode_q  <= nxt_mode;
         cur_start_q <= nxt_start;
         beat_valid  <= nxt_active;
         beat_idx    <= nxt_active ? idx_tab[nxt_cnt] : '0;
         beat_idle   <= nxt_active && idle_tab[nxt_cnt];
         burst_done  <= nxt_active && (nxt_cnt == LAST);
         len_err     <= nxt_active && nxt_mode.err;
      end
   end

   property p_idle_blank;
      @(posedge clk) disable iff (!rst_n)
         beat_idle |-> (beat_valid && beat_idx == '0);
   endproperty
   assert_idle_blank_R7: assert property (p_idle_blank)
      else $error("idle slot with data index");

   property p_burst_continues;
      @(posedge clk) disable iff (!rst_n)
         (beat_valid && !burst_done) |=> beat_valid;
   endproperty
   assert_burst_continues_R2: assert property (p_burst_continues)
      else $error("burst ended before eighth slot");

   property p_done_in_burst;
      @(posedge clk) disable iff (!rst_n)
         burst_done |-> beat_valid;
   endproperty
   assert_done_in_burst_R2: assert property (p_done_in_burst)
      else $error("done pulse outside burst");

   property p_idle_tail;
      @(posedge clk) disable iff (!rst_n)
         (beat_idle && !burst_done) |=> beat_idle;
   endproperty
   assert_idle_tail_R6: assert property (p_idle_tail)
      else $error("idle tail interrupted");

   property p_err_steady;
      @(posedge clk) disable iff (!rst_n)
         (len_err && !burst_done) |=> len_err;
   endproperty
   assert_err_steady_R9: assert property (p_err_steady)
      else $error("length error flag dropped mid burst");

   property p_err_valid;
      @(posedge clk) disable iff (!rst_n)
         len_err |-> beat_valid;
   endproperty
   assert_err_valid_R9: assert property (p_err_valid)
      else $error("length error outside burst");

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
   import burst_order_pkg::*;
#(
   parameter int BEATS = 8,
   localparam int IDX_W = $clog2(BEATS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic             cmd_chop,
   input  logic [IDX_W-1:0] cmd_start,
   input  logic [1:0]       mode_len,
   input  logic             mode_ilv,
   output logic             beat_valid,
   output logic [IDX_W-1:0] beat_idx,
   output logic             beat_idle,
   output logic             burst_done,
   output logic             len_err
);

   if (BEATS < 4 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 4");
   end

   logic             dec_chop;
   logic             dec_err;
   burst_mode_t      in_mode;
   logic             seq_free;
   logic             launch_valid;
   burst_mode_t      launch_mode;
   logic [IDX_W-1:0] launch_start;

   burst_len_decode i_decode (
      .len_code (mode_len),
      .cmd_chop (cmd_chop),
      .chop     (dec_chop),
      .err      (dec_err)
   );

   always_comb begin
      in_mode.write = cmd_write;
      in_mode.chop  = dec_chop;
      in_mode.ilv   = mode_ilv;
      in_mode.err   = dec_err;
   end

   burst_cmd_slot #(.IDX_W(IDX_W)) i_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_mode     (in_mode),
      .cmd_start    (cmd_start),
      .seq_free     (seq_free),
      .launch_valid (launch_valid),
      .launch_mode  (launch_mode),
      .launch_start (launch_start)
   );

   beat_sequencer #(.BEATS(BEATS)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_valid (launch_valid),
      .launch_mode  (launch_mode),
      .launch_start (launch_start),
      .seq_free     (seq_free),
      .beat_valid   (beat_valid),
      .beat_idx     (beat_idx),
      .beat_idle    (beat_idle),
      .burst_done   (burst_done),
      .len_err      (len_err)
   );

   property p_first_beat;
      @(posedge clk) disable iff (!rst_n)
         (cmd_valid && !beat_valid) |=> beat_valid;
   endproperty
   assert_first_beat_R2: assert property (p_first_beat)
      else $error("no beat one cycle after strobe on idle block");

endmodule

// File: tb/test_burst_order_gen.sv
`timescale 1ns/1ps
module test_burst_order_gen;

   typedef struct {
      int         cyc;
      logic [2:0] idx;
      logic       idle;
      logic       done;
      logic       err;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_write = 1'b0;
   logic       cmd_chop = 1'b0;
   logic [2:0] cmd_start = '0;
   logic [1:0] mode_len = '0;
   logic       mode_ilv = 1'b0;
   logic       beat_valid;
   logic [2:0] beat_idx;
   logic       beat_idle;
   logic       burst_done;
   logic       len_err;

   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   int    last_start = -100;
   int    tail = -100;
   bit    mon_on = 1'b0;
   string quiet_tag = "R2";
   exp_t  sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   burst_order_gen i_burst_order_gen (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_chop(cmd_chop), .cmd_start(cmd_start), .mode_len(mode_len),
      .mode_ilv(mode_ilv), .beat_valid(beat_valid), .beat_idx(beat_idx),
      .beat_idle(beat_idle), .burst_done(burst_done), .len_err(len_err)
   );

   function automatic logic [2:0] ref_index(bit wr, bit chop, bit ilv, logic [2:0] s, int k);
      int base, off;
      if (wr && !chop) return 3'(k);
      if (wr && chop) return 3'((s & 4) + k);
      base = s & 4;
      if (ilv) return 3'(s ^ k);
      off = ((s & 3) + k) % 4;
      return 3'((k < 4) ? base + off : (4 - base) + off);
   endfunction

   task automatic issue(bit wr, bit chp, logic [1:0] len, bit ilv, logic [2:0] s, string tag);
      int   n, st;
      bit   chop;
      exp_t e;
      n = cyc;
      cmd_valid = 1'b1; cmd_write = wr; cmd_chop = chp;
      mode_len = len; mode_ilv = ilv; cmd_start = s;
      chop = (len == 2'b10) || (len == 2'b01 && chp);
      if (last_start <= n + 1) begin
         st = (n + 1 > tail + 1) ? n + 1 : tail + 1;
         last_start = st;
         tail = st + 7;
         for (int k = 0; k < 8; k++) begin
            e.cyc  = st + k;
            e.idle = chop && k >= 4;
            e.idx  = e.idle ? 3'd0 : ref_index(wr, chop, ilv, s, k);
            e.done = (k == 7);
            e.err  = (len == 2'b11);
            e.tag  = tag;
            sb.push_back(e);
         end
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic settle();
      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic fail_line(string tag, string what, int act, int exp);
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (sb.size() != 0 && sb[0].cyc == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (beat_valid !== 1'b1 || beat_idx !== e.idx || beat_idle !== e.idle ||
                burst_done !== e.done || len_err !== e.err)
               fail_line(e.tag, "beat {valid,idx,idle,done,err}",
                         {beat_valid, beat_idx, beat_idle, burst_done, len_err},
                         {1'b1, e.idx, e.idle, e.done, e.err});
         end else begin
            checks++;
            if (beat_valid !== 1'b0 || beat_idle !== 1'b0 || burst_done !== 1'b0 || len_err !== 1'b0)
               fail_line(quiet_tag, "quiet cycle {valid,idle,done,err}",
                         {beat_valid, beat_idle, burst_done, len_err}, 0);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;   // R1 reset state
      if ({beat_valid, beat_idx, beat_idle, burst_done, len_err} !== 7'd0)
         fail_line("R1", "outputs in reset", {beat_valid, beat_idx, beat_idle, burst_done, len_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R1 first cycle after reset
      if ({beat_valid, beat_idx, beat_idle, burst_done, len_err} !== 7'd0)
         fail_line("R1", "outputs after reset", {beat_valid, beat_idx, beat_idle, burst_done, len_err}, 0);
      mon_on = 1'b1;

      issue(1'b0, 1'b0, 2'b00, 1'b0, 3'd5, "R3"); settle();
      issue(1'b0, 1'b0, 2'b00, 1'b1, 3'd3, "R4"); settle();
      issue(1'b0, 1'b0, 2'b00, 1'b0, 3'd0, "R3"); settle();
      issue(1'b1, 1'b0, 2'b00, 1'b1, 3'd6, "R5"); settle();
      issue(1'b1, 1'b1, 2'b00, 1'b0, 3'd3, "R5"); settle();
      issue(1'b1, 1'b0, 2'b10, 1'b0, 3'd7, "R6"); settle();
      issue(1'b1, 1'b1, 2'b01, 1'b1, 3'd2, "R6"); settle();
      issue(1'b0, 1'b0, 2'b10, 1'b0, 3'd6, "R7"); settle();
      issue(1'b0, 1'b1, 2'b01, 1'b1, 3'd5, "R7"); settle();
      issue(1'b0, 1'b0, 2'b01, 1'b0, 3'd1, "R8"); settle();
      issue(1'b0, 1'b0, 2'b10, 1'b1, 3'd2, "R8"); settle();
      issue(1'b0, 1'b1, 2'b11, 1'b0, 3'd2, "R9"); settle();
      issue(1'b1, 1'b1, 2'b11, 1'b1, 3'd4, "R9"); settle();

      // R10 held command, R11 third strobe dropped
      quiet_tag = "R11";
      issue(1'b0, 1'b0, 2'b00, 1'b0, 3'd2, "R10");
      issue(1'b0, 1'b1, 2'b01, 1'b1, 3'd7, "R10");
      issue(1'b1, 1'b0, 2'b00, 1'b0, 3'd1, "R11");
      settle();
      // R11 strobe in the cycle the held command launches is kept
      issue(1'b0, 1'b0, 2'b00, 1'b1, 3'd1, "R10");
      repeat (2) @(negedge clk);
      issue(1'b0, 1'b0, 2'b10, 1'b0, 3'd3, "R10");
      while (cyc < last_start - 1) @(negedge clk);
      issue(1'b1, 1'b1, 2'b10, 1'b0, 3'd5, "R11");
      settle();
      // R10 strobe in the eighth slot starts straight after it
      issue(1'b0, 1'b0, 2'b00, 1'b1, 3'd6, "R10");
      while (cyc < tail) @(negedge clk);
      issue(1'b0, 1'b0, 2'b00, 1'b0, 3'd4, "R10");
      settle();
      quiet_tag = "R2";

      // R12 inputs scrambled during a burst
      issue(1'b0, 1'b0, 2'b00, 1'b0, 3'd5, "R12");
      for (int j = 0; j < 6; j++) begin
         cmd_write = ~cmd_write; cmd_chop = ~cmd_chop; mode_ilv = ~mode_ilv;
         cmd_start = cmd_start + 3'd3; mode_len = mode_len + 2'd1;
         @(negedge clk);
      end
      settle();

      mon_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule